// File: doc/BRIEF.md
# Register-Mapped SPI Master Core

This block is an SPI master that a processor runs through a small bank of 32-bit registers. Software picks one of eight slave devices by index and asserts its active-low select. It sets clock polarity, clock phase, word size and the bit order of each direction. A write of the outgoing word then starts one full-duplex exchange. When the word has been shifted, a completion flag is raised. Software reads the received word and clears the flag before it starts the next word.

The serial clock advances on a one-cycle tick pulse from an external divider. Each tick moves the serial clock by one edge, so a word of N bits takes 2N ticks. A programmable delay of zero, one or two system clocks between the nominal sample edge and the capture of the input line makes up for slow round-trip paths at high bit rates.

Top module: `spim_core`

## Requirements
- R1: Register byte offsets are control 0x00, configuration 0x04, data-out 0x08, data-in 0x0C, completion 0x10 and timing 0x18. Undefined bits and unmapped offsets read as zero. After reset the timing register reads 0x40 and the other registers read zero.
- R2: Control bit 0 asserts a select and control bits 4:2 hold the index. Output line cs_no[index] is driven low only while bit 0 is set, and all other lines stay high. The select outputs change only on the clock edge of a control write.
- R3: SCLK rests at the level of configuration bit 11 while idle. During an exchange it toggles once per tick, makes 2N edges for an N-bit word, and ends at the resting level.
- R4: Configuration bit 12 clear: the first bit is on MOSI before the first edge, and MISO is sampled on leading edges. Set: data is launched on leading edges and sampled on trailing edges.
- R5: Configuration bit 5 set selects 16-bit words and clear selects 8-bit words. The word occupies bits 15:0 or 7:0 of data-out and data-in. Higher data-out bits are ignored, and higher data-in bits read zero.
- R6: Configuration bit 13 sends LSB first and bit 14 receives LSB first. The two are independent, and a clear bit means MSB first.
- R7: A data-out write while idle starts an exchange, and control bit 8 reads 1 while it runs. At completion bit 0 of the completion register reads 1 until any write to that register clears it.
- R8: A data-out write during an exchange is ignored. Neither the transmitted bits nor the received word change.
- R9: Timing bits 7:6 (reset value 1) set how many system clocks after a sample edge MISO is captured: 0, 1 or 2. The value 3 acts as 2.
- R10: After reset all select lines are high, SCLK is low and no exchange runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| sclk_tick_i | input | 1 | One-cycle pulse per SCLK edge from the divider |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_no | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the core with its default of eight select lines and a three-bit index. This puts both the lowest and the highest select line within reach, as well as a deassert write that carries a nonzero index. A slave model in the bench drives each received bit on MISO with three different values: one at the sample edge and one on each of the two clocks after it. This makes every capture delay give a distinct received word. The runs cover all four clock modes, both word sizes, each bit-order flag on its own, and a data-out write in the middle of a running exchange.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int WORD_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CFG    = 5'h04;
  localparam logic [ADDR_W-1:0] A_DOUT   = 5'h08;
  localparam logic [ADDR_W-1:0] A_DIN    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 5'h10;
  localparam logic [ADDR_W-1:0] A_TIMING = 5'h18;

  localparam int B_CS_EN  = 0;
  localparam int B_CS_IDX = 2;
  localparam int B_BUSY   = 8;
  localparam int B_WIDE   = 5;
  localparam int B_CPOL   = 11;
  localparam int B_CPHA   = 12;
  localparam int B_TXLSB  = 13;
  localparam int B_RXLSB  = 14;
  localparam int B_DLY    = 6;

  typedef struct packed {
    logic rx_lsb;
    logic tx_lsb;
    logic cpha;
    logic cpol;
    logic wide;
  } mode_t;

  // Right-aligned word of 8 or 16 bits, optionally bit-reversed within its size
  function automatic logic [WORD_W-1:0] order_word(input logic [WORD_W-1:0] w,
                                                   input logic wide, input logic rev);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (wide) r[i] = rev ? w[WORD_W-1-i] : w[i];
      else if (i < WORD_W/2) r[i] = rev ? w[WORD_W/2-1-i] : w[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/spim_csdec.sv
module spim_csdec #(
  parameter int NUM_CS = 8,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            en_i,
  input  logic [CS_W-1:0] idx_i,
  output logic [NUM_CS-1:0] cs_no
);
  // One register per line, all loaded by the same write: no intermediate codes
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cs_no[g] <= 1'b1;
      else if (load_i) cs_no[g] <= !(en_i && (idx_i == CS_W'(g)));
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs import spim_pkg::*; #(
  parameter int NUM_CS = 8,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              start_o,
  output logic [WORD_W-1:0] tx_word_o,
  output mode_t             mode_o,
  output logic [1:0]        dly_o,
  output logic              cs_load_o
);
  logic            cs_en_q;
  logic [CS_W-1:0] cs_idx_q;
  mode_t           mode_q;
  logic [1:0]      tdly_q;
  logic            cause_q;
  logic [WORD_W-1:0] din_q;
  logic            unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:WORD_W];
  assign start_o   = we_i && (addr_i == A_DOUT) && !busy_i;
  assign tx_word_o = wdata_i[WORD_W-1:0];
  assign cs_load_o = we_i && (addr_i == A_CTRL);
  assign mode_o    = mode_q;
  assign dly_o     = (tdly_q == 2'd3) ? 2'd2 : tdly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_idx_q <= '0;
      mode_q   <= '0;
      tdly_q   <= 2'd1;
      cause_q  <= 1'b0;
      din_q    <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_CTRL: begin
            cs_en_q  <= wdata_i[B_CS_EN];
            cs_idx_q <= wdata_i[B_CS_IDX +: CS_W];
          end
          A_CFG: mode_q <= '{rx_lsb: wdata_i[B_RXLSB], tx_lsb: wdata_i[B_TXLSB],
                             cpha: wdata_i[B_CPHA], cpol: wdata_i[B_CPOL],
                             wide: wdata_i[B_WIDE]};
          A_TIMING: tdly_q <= wdata_i[B_DLY +: 2];
          default: ;
        endcase
      end
      if (done_i) begin
        cause_q <= 1'b1;
        din_q   <= rx_word_i;
      end else if (we_i && addr_i == A_CAUSE) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_CS_EN]            = cs_en_q;
        rdata_o[B_CS_IDX +: CS_W]   = cs_idx_q;
        rdata_o[B_BUSY]             = busy_i;
      end
      A_CFG: begin
        rdata_o[B_WIDE]  = mode_q.wide;
        rdata_o[B_CPOL]  = mode_q.cpol;
        rdata_o[B_CPHA]  = mode_q.cpha;
        rdata_o[B_TXLSB] = mode_q.tx_lsb;
        rdata_o[B_RXLSB] = mode_q.rx_lsb;
      end
      A_DIN:    rdata_o[WORD_W-1:0] = din_q;
      A_CAUSE:  rdata_o[0] = cause_q;
      A_TIMING: rdata_o[B_DLY +: 2] = tdly_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  mode_t             mode_i,
  input  logic [1:0]        dly_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int EDGE_W = $clog2(2*WORD_W) + 1;

  logic              busy_q, sclk_q;
  mode_t             mode_q;
  logic [1:0]        dly_q, pipe_q;
  logic [EDGE_W-1:0] edge_q, n_edges;
  logic [WORD_W-1:0] txsh_q, rxsh_q;
  logic              edges_done, edge_ev, smp_ev, launch_ev, cap, fin;

  assign n_edges    = mode_q.wide ? EDGE_W'(2*WORD_W) : EDGE_W'(WORD_W);
  assign edges_done = (edge_q == n_edges);
  assign edge_ev    = busy_q && tick_i && !edges_done;
  // even edges are leading; sampling edge parity follows the phase bit
  assign smp_ev     = edge_ev && (edge_q[0] == mode_q.cpha);
  assign launch_ev  = edge_ev && (edge_q[0] != mode_q.cpha) && (edge_q != '0);
  assign cap        = (dly_q == 2'd0) ? smp_ev : (dly_q == 2'd1) ? pipe_q[0] : pipe_q[1];
  assign fin        = busy_q && edges_done && (pipe_q == 2'b00);

  assign busy_o    = busy_q;
  assign done_o    = fin;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mode_q.wide ? txsh_q[WORD_W-1] : txsh_q[WORD_W/2-1];
  assign rx_word_o = order_word(rxsh_q, mode_q.wide, mode_q.rx_lsb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mode_q <= '0;
      dly_q  <= 2'd0;
      pipe_q <= 2'b00;
      edge_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      pipe_q <= {pipe_q[0], smp_ev};
      if (!busy_q) begin
        sclk_q <= mode_i.cpol;
        if (start_i) begin
          busy_q <= 1'b1;
          mode_q <= mode_i;
          dly_q  <= dly_i;
          edge_q <= '0;
          txsh_q <= order_word(tx_word_i, mode_i.wide, mode_i.tx_lsb);
        end
      end else begin
        if (edge_ev) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
        end
        if (launch_ev) txsh_q <= txsh_q << 1;
        if (cap)       rxsh_q <= {rxsh_q[WORD_W-2:0], miso_i};
        if (fin)       busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spim_core.sv
module spim_core import spim_pkg::*; #(
  parameter int NUM_CS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              sclk_tick_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_no
);
  localparam int CS_W = $clog2(NUM_CS);

  logic              busy_w, done_w, start_w, cs_load_w;
  logic [WORD_W-1:0] tx_w, rx_w;
  mode_t             mode_w;
  logic [1:0]        dly_w;

  spim_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_w), .done_i(done_w), .rx_word_i(rx_w),
    .start_o(start_w), .tx_word_o(tx_w), .mode_o(mode_w), .dly_o(dly_w),
    .cs_load_o(cs_load_w)
  );

  spim_csdec #(.NUM_CS(NUM_CS)) u_csdec (
    .clk_i, .rst_ni,
    .load_i(cs_load_w), .en_i(reg_wdata_i[B_CS_EN]),
    .idx_i(reg_wdata_i[B_CS_IDX +: CS_W]), .cs_no(cs_no)
  );

  spim_engine u_engine (
    .clk_i, .rst_ni,
    .start_i(start_w), .tx_word_i(tx_w), .mode_i(mode_w), .dly_i(dly_w),
    .tick_i(sclk_tick_i), .miso_i(miso_i),
    .busy_o(busy_w), .done_o(done_w), .rx_word_o(rx_w),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );
endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk import spim_pkg::*; #(
  parameter int NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [4:0]        reg_addr_i,
  input logic              sclk_tick_i,
  input logic              sclk_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic              busy_i,
  input logic              done_i,
  input logic              cpol_i
);
  p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_cs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_CTRL) |=> $stable(cs_no));

  p_idle_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (sclk_o == $past(cpol_i)));

  p_edge_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !sclk_tick_i) |=> $stable(sclk_o));

  p_done_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i);

  p_busy_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i && reg_we_i && reg_addr_i == A_DOUT) |=> busy_i);
endmodule

bind spim_core spim_core_chk #(.NUM_CS(NUM_CS)) i_spim_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .sclk_tick_i(sclk_tick_i), .sclk_o(sclk_o), .cs_no(cs_no),
  .busy_i(busy_w), .done_i(done_w), .cpol_i(mode_w.cpol)
);

// File: tb/test_spim_core.sv
module test_spim_core;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 8;
  localparam int WDOG = 100000;

  localparam logic [4:0] CTRL = 5'h00, CFG = 5'h04, DOUT = 5'h08,
                         DIN = 5'h0C, CAUSE = 5'h10, TIMING = 5'h18;

  logic clk = 0, rst_n = 0;
  logic we = 0, tick = 0, miso = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi;
  logic [NUM_CS-1:0] cs_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_cpol, m_cpha, m_wide, m_txl, m_rxl;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_core #(.NUM_CS(NUM_CS)) i_spim_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_tick_i(tick),
    .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic setmode(input bit cpol, cpha, wide, txl, rxl);
    m_cpol = cpol; m_cpha = cpha; m_wide = wide; m_txl = txl; m_rxl = rxl;
    wr(CFG, (32'(rxl) << 14) | (32'(txl) << 13) | (32'(cpha) << 12) |
            (32'(cpol) << 11) | (32'(wide) << 5));
    @(negedge clk);
  endtask

  // Slave model: bit s driven as w0 up to the sample edge, w1 and w2 on the next two clocks
  task automatic xfer(input string tag, input logic [31:0] tx, input logic [15:0] w0,
                      input logic [15:0] w1, input logic [15:0] w2, input int dsel,
                      input bit poke, input logic [31:0] poke_val);
    int n;
    logic [15:0] msk, mo, wexp;
    logic [31:0] d;
    bit sclk_ok;
    n = m_wide ? 16 : 8;
    msk = m_wide ? 16'hFFFF : 16'h00FF;
    mo = '0; sclk_ok = 1;
    wexp = (dsel == 0) ? w0 : (dsel == 1) ? w1 : w2;
    wr(DOUT, tx);
    for (int k = 0; k < 2*n; k++) begin
      bit smp;
      int s, bi;
      smp = ((k % 2) == int'(m_cpha));
      s = k / 2;
      bi = m_rxl ? s : n - 1 - s;
      if (smp) begin
        miso = w0[bi];
        if (m_txl) mo[s] = mosi; else mo[n-1-s] = mosi;
      end
      tick = 1;
      @(negedge clk); tick = 0;
      if (smp) begin
        if (sclk !== (m_cpha ? m_cpol : !m_cpol)) sclk_ok = 0;
        miso = w1[bi];
      end
      @(negedge clk); if (smp) miso = w2[bi];
      @(negedge clk);
      if (poke && k == 2) begin
        rd(CTRL, d);
        chk({tag, " R7 busy bit during exchange"}, 32'(d[8]), 32'd1);
        wr(DOUT, poke_val);
      end
    end
    repeat (6) @(negedge clk);
    chk({tag, " R4 sclk level at sample edges"}, 32'(sclk_ok), 32'd1);
    chk({tag, " R3 sclk back at rest"}, 32'(sclk), 32'(m_cpol));
    chk({tag, " R6 mosi bits"}, 32'(mo), 32'(tx[15:0] & msk));
    rd(CAUSE, d);
    chk({tag, " R7 completion flag"}, d, 32'd1);
    rd(DIN, d);
    chk({tag, " R5 received word"}, d, 32'(wexp & msk));
    wr(CAUSE, 32'h0);
    rd(CAUSE, d);
    chk({tag, " R7 flag cleared"}, d, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 selects high", 32'(cs_n), 32'(8'hFF));
    chk("R10 sclk low", 32'(sclk), 32'd0);
    rd(CTRL, d);   chk("R10 ctrl idle", d, 32'h0);
    rd(CFG, d);    chk("R1 cfg reset", d, 32'h0);
    rd(TIMING, d); chk("R1 timing reset", d, 32'h40);
    rd(CAUSE, d);  chk("R1 cause reset", d, 32'h0);
    rd(5'h14, d);  chk("R1 unmapped", d, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(CTRL, 32'h0000_0015);            // index 5, asserted
    chk("R2 index 5", 32'(cs_n), 32'(8'hDF));
    rd(CTRL, d); chk("R1 ctrl readback", d, 32'h15);
    wr(CTRL, 32'h0000_001D);            // index 7
    chk("R2 index 7", 32'(cs_n), 32'(8'h7F));
    wr(CTRL, 32'h0000_0001);            // index 0
    chk("R2 index 0", 32'(cs_n), 32'(8'hFE));
    wr(CFG, 32'h0000_1800);
    chk("R2 hold on other write", 32'(cs_n), 32'(8'hFE));
    wr(CFG, 32'h0);
    wr(CTRL, 32'h0000_001C);            // index 7, not asserted
    chk("R2 deasserted", 32'(cs_n), 32'(8'hFF));
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    setmode(1, 1, 1, 1, 1);
    rd(CFG, d); chk("R1 cfg readback", d, 32'h0000_7820);
    chk("R3 idle at cpol 1", 32'(sclk), 32'd1);
    setmode(0, 0, 0, 0, 0);
    chk("R3 idle at cpol 0", 32'(sclk), 32'd0);
  endtask

  task automatic t_modes;
    setmode(0, 0, 0, 0, 0); xfer("mode0", 32'hA5, 16'h3C, 16'h3C, 16'h3C, 1, 0, 0);
    setmode(0, 1, 0, 0, 0); xfer("mode1", 32'h96, 16'hC1, 16'hC1, 16'hC1, 1, 0, 0);
    setmode(1, 0, 0, 0, 0); xfer("mode2", 32'h0F, 16'h81, 16'h81, 16'h81, 1, 0, 0);
    setmode(1, 1, 0, 0, 0); xfer("mode3", 32'hE2, 16'h5A, 16'h5A, 16'h5A, 1, 0, 0);
  endtask

  task automatic t_width_order;
    setmode(0, 0, 1, 0, 0); xfer("R5 wide", 32'h0000_B3C1, 16'h4E71, 16'h4E71, 16'h4E71, 1, 0, 0);
    setmode(1, 1, 0, 0, 0); xfer("R5 narrow upper ignored", 32'hABCD_1234, 16'hFF6B, 16'hFF6B, 16'hFF6B, 1, 0, 0);
    setmode(0, 0, 0, 1, 0); xfer("R6 tx lsb", 32'h0000_00C8, 16'h0013, 16'h0013, 16'h0013, 1, 0, 0);
    setmode(0, 1, 1, 0, 1); xfer("R6 rx lsb", 32'h0000_8421, 16'h1E03, 16'h1E03, 16'h1E03, 1, 0, 0);
  endtask

  task automatic t_delay;
    setmode(0, 0, 0, 0, 0);
    wr(TIMING, 32'h0000_0000); xfer("R9 delay 0", 32'h55, 16'h3A, 16'hC5, 16'h69, 0, 0, 0);
    wr(TIMING, 32'h0000_0040); xfer("R9 delay 1", 32'h55, 16'h3A, 16'hC5, 16'h69, 1, 0, 0);
    wr(TIMING, 32'h0000_0080); xfer("R9 delay 2", 32'h55, 16'h3A, 16'hC5, 16'h69, 2, 0, 0);
    setmode(1, 1, 1, 0, 0);
    wr(TIMING, 32'h0000_00C0); xfer("R9 delay 3 acts as 2", 32'h1234, 16'hA0F5, 16'h5F0A, 16'hC33C, 2, 0, 0);
    wr(TIMING, 32'h0000_0040);
  endtask

  task automatic t_busy;
    setmode(0, 1, 0, 0, 0);
    xfer("R8 write during exchange", 32'h6D, 16'h92, 16'h92, 16'h92, 1, 1, 32'h0000_00FF);
    setmode(1, 0, 1, 1, 1);
    xfer("R8 wide write during exchange", 32'hC0DE, 16'h7E81, 16'h7E81, 16'h7E81, 1, 1, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_cfg();
    t_modes();
    t_width_order();
    t_delay();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule